// File: doc/BRIEF.md
# Dual-Channel Request Front End with Busy Handshake

This block sits between two memory clients and the access scheduler of a shared memory controller. Each client presents a request by raising an asynchronous strobe, with a read/write select, an address and write data already set up. The strobe is brought into the controller clock domain by a chain of flip-flops clocked on the falling clock edge. Each rise of the strobe becomes one start pulse that lasts exactly one controller clock period, and the rising edge samples that pulse.

On capture, the block stores the request fields, raises the client's busy flag and presents a pending request to the scheduler. When the scheduler takes the request (accept), pending drops and busy stays high. When the scheduler reports completion, busy drops. For a read, the returned data is loaded on the same edge at which busy falls, and a one-cycle read-valid pulse marks it. The initialization-done input holds every busy flag high and discards all queued state until the memory behind the block is ready. The channels are copies of one slice and share nothing except the clock, the reset, the readiness input and the read-data bus from the scheduler.

Top module: `chan_req_frontend`

## Requirements
- R1: While reset is asserted, and afterwards while init_done is low, every busy output is 1, every pending output is 0 and every read-valid output is 0.
- R2: A strobe rise that arrives while the block is not yet ready (init_done low, or in the edge at which it is first registered high) is discarded: once ready, busy and pending are 0.
- R3: With the channel idle and ready, a strobe raised just after a rising edge is captured at the next rising edge, because a falling edge lies between them. After that edge busy and pending are both 1.
- R4: A strobe held high produces one request only. No second request is captured until the strobe has been low across two falling edges and rises again.
- R5: The request outputs (write flag, address, write data) take the client's values at capture and hold them while busy is high, even if the client inputs change.
- R6: An accept while pending clears pending at the next rising edge and leaves busy at 1. An accept when not pending has no effect.
- R7: A completion while serving (accepted, not yet done) clears busy at the next rising edge. A completion while idle or still pending has no effect.
- R8: On completion of a read (write flag 0), the read-data output takes the scheduler read data at the same edge where busy falls, and read-valid is 1 for exactly that one cycle. On completion of a write (write flag 1), read-valid stays 0 and the read-data output is unchanged.
- R9: A strobe rise while busy is high is dropped: after the current request completes, the channel stays idle with pending 0.
- R10: init_done going low during a request forces busy to 1 and pending to 0 at the next rising edge, and discards the request. After init_done returns, the channel is idle and ready.
- R11: The channels act independently: activity on one channel changes no output of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; the synchronizer uses its falling edge, all other state its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done | input | 1 | High once the memory behind the block is initialized |
| cl_strobe | input | NUM_CH | Per-channel asynchronous request strobe |
| cl_write | input | NUM_CH | Per-channel select: 0 read, 1 write |
| cl_addr | input | NUM_CH x ADDR_W | Per-channel request address |
| cl_wdata | input | NUM_CH x DATA_W | Per-channel write data |
| cl_busy | output | NUM_CH | Per-channel busy flag returned to the client |
| cl_rdata | output | NUM_CH x DATA_W | Per-channel read data, valid when busy falls after a read |
| cl_rvalid | output | NUM_CH | One-cycle pulse marking new read data |
| sc_accept | input | NUM_CH | Scheduler has taken the pending request |
| sc_complete | input | NUM_CH | Scheduler has finished the accepted request |
| sc_rdata | input | DATA_W | Read data from the scheduler, sampled by the completing channel |
| rq_pending | output | NUM_CH | A captured request waits for the scheduler |
| rq_write | output | NUM_CH | Latched write flag |
| rq_addr | output | NUM_CH x ADDR_W | Latched address |
| rq_wdata | output | NUM_CH x DATA_W | Latched write data |

## Verification
A slice stuck in the wrong state shows up at the ports within one rising edge. A channel left pending after accept keeps rq_pending high. A channel that misses a completion keeps its client busy and never pulses read-valid. A synchronizer that produced repeated start pulses would capture a second request right after a held-strobe request completes, and pending would rise again one edge later. A read-data register loaded at the wrong moment gives a mismatch on the very cycle busy falls. The directed scenarios therefore sample busy, pending and the latched fields one edge after each strobe, accept, completion and readiness change, and they check that ignored events leave those outputs unchanged.

// File: rtl/creq_pkg.sv
package creq_pkg;

    // Life cycle of one channel's request slot.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no request held, client may strobe
        ST_PEND = 2'd1,   // captured, waiting for the scheduler to take it
        ST_SERV = 2'd2    // taken by the scheduler, waiting for completion
    } creq_state_e;

    // Minimum length of the falling-edge synchronizer chain.
    localparam int unsigned CREQ_MIN_STAGES = 2;

endpackage

// File: rtl/creq_sync.sv
module creq_sync
    import creq_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic start
);

    localparam int unsigned LAST = STAGES - 1;
    localparam int unsigned PREV = STAGES - 2;

    logic [STAGES-1:0] stg_d;
    logic [STAGES-1:0] stg_q;

    generate
        if (STAGES < CREQ_MIN_STAGES) begin : g_bad_depth
            initial begin
                $display("creq_sync: STAGES must be at least %0d", CREQ_MIN_STAGES);
            end
        end
    endgenerate

    // Shift the raw strobe in at stage 0; the last two stages form the edge detector.
    always_comb begin
        stg_d = {stg_q[STAGES-2:0], strobe};
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    // High for one full clock period, from one falling edge to the next.
    assign start = stg_q[PREV] & ~stg_q[LAST];

    // R4: the start pulse never lasts beyond one falling-edge interval.
    a_r4_single_start : assert property (@(negedge clk) disable iff (!rst_n)
        start |=> !start);

endmodule

// File: rtl/creq_chan.sv
module creq_chan
    import creq_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_in,
    input  logic              start,
    input  logic              cl_write,
    input  logic [ADDR_W-1:0] cl_addr,
    input  logic [DATA_W-1:0] cl_wdata,
    input  logic              sc_accept,
    input  logic              sc_complete,
    input  logic [DATA_W-1:0] sc_rdata,
    output logic              busy,
    output logic              pending,
    output logic              rq_write,
    output logic [ADDR_W-1:0] rq_addr,
    output logic [DATA_W-1:0] rq_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    typedef struct packed {
        creq_state_e       state;
        logic              rdy;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } chan_regs_t;

    chan_regs_t r_d;
    chan_regs_t r_q;

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        r_d.rdy    = init_in;
        if (!init_in) begin
            // Readiness lost: drop whatever was held.
            r_d.state = ST_IDLE;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (start && r_q.rdy) begin
                        r_d.state = ST_PEND;
                        r_d.wr    = cl_write;
                        r_d.addr  = cl_addr;
                        r_d.wdata = cl_wdata;
                    end
                end
                ST_PEND: begin
                    if (sc_accept) begin
                        r_d.state = ST_SERV;
                    end
                end
                ST_SERV: begin
                    if (sc_complete) begin
                        r_d.state = ST_IDLE;
                        if (!r_q.wr) begin
                            r_d.rdata  = sc_rdata;
                            r_d.rvalid = 1'b1;
                        end
                    end
                end
                default: begin
                    r_d.state = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, rdy: 1'b0, wr: 1'b0, addr: '0,
                     wdata: '0, rdata: '0, rvalid: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.state != ST_IDLE) || !r_q.rdy;
    assign pending  = (r_q.state == ST_PEND);
    assign rq_write = r_q.wr;
    assign rq_addr  = r_q.addr;
    assign rq_wdata = r_q.wdata;
    assign rdata    = r_q.rdata;
    assign rvalid   = r_q.rvalid;

    // R3: a visible pending request always comes with busy set.
    a_r3_pend_busy : assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> busy);

    // R5: latched fields hold while busy stays high.
    a_r5_fields_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(rq_addr) && $stable(rq_wdata) && $stable(rq_write)));

    // R6: an accepted request leaves pending but keeps the client busy.
    a_r6_accept : assert property (@(posedge clk) disable iff (!rst_n)
        (pending && sc_accept && init_in) |=> (!pending && busy));

    // R8: read-valid only appears with busy low, and never twice in a row.
    a_r8_rvalid_idle : assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (!busy && !pending));
    a_r8_rvalid_pulse : assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    // R9: no new capture can follow a cycle in which busy was high.
    a_r9_busy_blocks : assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !$rose(pending));

    // R10: loss of readiness flushes the slot and raises busy.
    a_r10_flush : assert property (@(posedge clk) disable iff (!rst_n)
        !init_in |=> (busy && !pending && !rvalid));

endmodule

// File: rtl/chan_req_frontend.sv
module chan_req_frontend
    import creq_pkg::*;
#(
    parameter int unsigned NUM_CH      = 2,
    parameter int unsigned ADDR_W      = 24,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           init_done,
    input  logic [NUM_CH-1:0]              cl_strobe,
    input  logic [NUM_CH-1:0]              cl_write,
    input  logic [NUM_CH-1:0][ADDR_W-1:0]  cl_addr,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  cl_wdata,
    output logic [NUM_CH-1:0]              cl_busy,
    output logic [NUM_CH-1:0][DATA_W-1:0]  cl_rdata,
    output logic [NUM_CH-1:0]              cl_rvalid,
    input  logic [NUM_CH-1:0]              sc_accept,
    input  logic [NUM_CH-1:0]              sc_complete,
    input  logic [DATA_W-1:0]              sc_rdata,
    output logic [NUM_CH-1:0]              rq_pending,
    output logic [NUM_CH-1:0]              rq_write,
    output logic [NUM_CH-1:0][ADDR_W-1:0]  rq_addr,
    output logic [NUM_CH-1:0][DATA_W-1:0]  rq_wdata
);

    logic [NUM_CH-1:0] start_pulse;

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
            creq_sync #(
                .STAGES (SYNC_STAGES)
            ) i_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .strobe (cl_strobe[ch]),
                .start  (start_pulse[ch])
            );

            creq_chan #(
                .ADDR_W (ADDR_W),
                .DATA_W (DATA_W)
            ) i_chan (
                .clk         (clk),
                .rst_n       (rst_n),
                .init_in     (init_done),
                .start       (start_pulse[ch]),
                .cl_write    (cl_write[ch]),
                .cl_addr     (cl_addr[ch]),
                .cl_wdata    (cl_wdata[ch]),
                .sc_accept   (sc_accept[ch]),
                .sc_complete (sc_complete[ch]),
                .sc_rdata    (sc_rdata),
                .busy        (cl_busy[ch]),
                .pending     (rq_pending[ch]),
                .rq_write    (rq_write[ch]),
                .rq_addr     (rq_addr[ch]),
                .rq_wdata    (rq_wdata[ch]),
                .rdata       (cl_rdata[ch]),
                .rvalid      (cl_rvalid[ch])
            );
        end
    endgenerate

    // R11: completions on one channel never raise read-valid on another.
    a_r11_rvalid_own : assert property (@(posedge clk) disable iff (!rst_n)
        ((cl_rvalid & ~$past(sc_complete)) == '0));

endmodule

// File: tb/test_chan_req_frontend.sv
module test_chan_req_frontend;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int AW  = 24;
    localparam int DW  = 8;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  init_done;
    logic [NCH-1:0]        strobe, wr, accept, complete;
    logic [NCH-1:0][AW-1:0] addr;
    logic [NCH-1:0][DW-1:0] wdata;
    logic [DW-1:0]         sc_rdata;
    logic [NCH-1:0]        busy, pending, rq_write, rvalid;
    logic [NCH-1:0][AW-1:0] rq_addr;
    logic [NCH-1:0][DW-1:0] rq_wdata, rdata;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_req_frontend #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW)) i_chan_req_frontend (
        .clk(clk), .rst_n(rst_n), .init_done(init_done),
        .cl_strobe(strobe), .cl_write(wr), .cl_addr(addr), .cl_wdata(wdata),
        .cl_busy(busy), .cl_rdata(rdata), .cl_rvalid(rvalid),
        .sc_accept(accept), .sc_complete(complete), .sc_rdata(sc_rdata),
        .rq_pending(pending), .rq_write(rq_write), .rq_addr(rq_addr), .rq_wdata(rq_wdata)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string tag, int unsigned act, int unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Full request on one channel: capture, accept, completion.
    task automatic run_req(int ch, bit is_wr, int unsigned a, int unsigned d,
                           int unsigned rd, bit keep_strobe = 0);
        logic [DW-1:0] old_rdata;
        wr[ch] = is_wr; addr[ch] = AW'(a); wdata[ch] = DW'(d);
        strobe[ch] = 1'b1;
        tick();
        chk("R3 busy after capture", busy[ch], 1);
        chk("R3 pending after capture", pending[ch], 1);
        chk("R5 latched addr", rq_addr[ch], a & 24'hFFFFFF);
        chk("R5 latched wdata", rq_wdata[ch], d & 8'hFF);
        chk("R5 latched write flag", rq_write[ch], is_wr);
        if (!keep_strobe) strobe[ch] = 1'b0;
        addr[ch] = ~addr[ch]; wdata[ch] = ~wdata[ch]; wr[ch] = ~wr[ch];
        accept[ch] = 1'b1;
        tick();
        accept[ch] = 1'b0;
        chk("R6 pending cleared by accept", pending[ch], 0);
        chk("R6 busy held after accept", busy[ch], 1);
        chk("R5 addr held while busy", rq_addr[ch], a & 24'hFFFFFF);
        chk("R5 write flag held while busy", rq_write[ch], is_wr);
        old_rdata = rdata[ch];
        sc_rdata = DW'(rd);
        complete[ch] = 1'b1;
        tick();
        complete[ch] = 1'b0;
        chk("R7 busy cleared by completion", busy[ch], 0);
        if (!is_wr) begin
            chk("R8 read data at busy fall", rdata[ch], rd & 8'hFF);
            chk("R8 read valid pulse", rvalid[ch], 1);
        end else begin
            chk("R8 no read valid on write", rvalid[ch], 0);
            chk("R8 read data unchanged on write", rdata[ch], old_rdata);
        end
        tick();
        chk("R8 read valid lasts one cycle", rvalid[ch], 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; init_done = 1'b0;
        strobe = '0; wr = '0; accept = '0; complete = '0;
        addr = '0; wdata = '0; sc_rdata = '0;
        tick(); tick();
        chk("R1 busy in reset", busy, 2'b11);
        chk("R1 pending in reset", pending, 0);
        chk("R1 rvalid in reset", rvalid, 0);
        rst_n = 1'b1;
        tick(); tick();
        chk("R1 busy until init done", busy, 2'b11);
        chk("R1 pending until init done", pending, 0);
    endtask

    task automatic t_not_ready();
        strobe[0] = 1'b1;
        tick(); tick();
        strobe[0] = 1'b0;
        tick();
        chk("R1 strobe during init leaves pending low", pending[0], 0);
        init_done = 1'b1;
        tick(); tick();
        chk("R2 busy low once ready", busy, 0);
        chk("R2 early strobe discarded", pending, 0);
    endtask

    task automatic t_read_write();
        run_req(0, 1'b0, 32'h12_3456, 32'hA5, 32'h3C);
        run_req(1, 1'b1, 32'hAB_CDEF, 32'h5A, 32'hFF);
        run_req(1, 1'b0, 32'h00_0001, 32'h00, 32'hC3);
    endtask

    task automatic t_held_strobe();
        run_req(0, 1'b1, 32'h77_0000, 32'h11, 32'h00, 1'b1);
        tick(); tick(); tick();
        chk("R4 held strobe gives no second request", pending[0], 0);
        chk("R4 held strobe leaves busy low", busy[0], 0);
        strobe[0] = 1'b0;
        tick(); tick();
        run_req(0, 1'b0, 32'h77_0001, 32'h22, 32'h99);
    endtask

    task automatic t_busy_strobe();
        wr[1] = 1'b0; addr[1] = 24'h0A0A0A; strobe[1] = 1'b1;
        tick();
        strobe[1] = 1'b0;
        tick(); tick();
        strobe[1] = 1'b1;  // illegal rise while busy
        addr[1] = 24'h0B0B0B;
        tick(); tick();
        strobe[1] = 1'b0;
        chk("R9 second rise keeps first fields", rq_addr[1], 24'h0A0A0A);
        accept[1] = 1'b1; tick(); accept[1] = 1'b0;
        complete[1] = 1'b1; tick(); complete[1] = 1'b0;
        chk("R9 busy low after completion", busy[1], 0);
        tick(); tick();
        chk("R9 dropped rise not queued", pending[1], 0);
        chk("R9 stays idle", busy[1], 0);
    endtask

    task automatic t_stray_events();
        complete[0] = 1'b1; accept[0] = 1'b1;
        tick();
        complete[0] = 1'b0; accept[0] = 1'b0;
        chk("R7 completion when idle ignored", busy[0], 0);
        chk("R6 accept when idle ignored", pending[0], 0);
        chk("R7 no read valid from idle completion", rvalid[0], 0);
        wr[0] = 1'b0; addr[0] = 24'h000042; strobe[0] = 1'b1;
        tick();
        strobe[0] = 1'b0;
        complete[0] = 1'b1;
        tick();
        complete[0] = 1'b0;
        chk("R7 completion while pending ignored (busy)", busy[0], 1);
        chk("R7 completion while pending ignored (pending)", pending[0], 1);
        accept[0] = 1'b1; tick(); accept[0] = 1'b0;
        sc_rdata = 8'h42;
        complete[0] = 1'b1; tick(); complete[0] = 1'b0;
        chk("R7 later completion honoured", busy[0], 0);
        chk("R8 read data after late completion", rdata[0], 8'h42);
    endtask

    task automatic t_flush();
        wr[0] = 1'b0; addr[0] = 24'h555555; strobe[0] = 1'b1;
        tick();
        strobe[0] = 1'b0;
        accept[0] = 1'b1; tick(); accept[0] = 1'b0;
        init_done = 1'b0;
        tick();
        chk("R10 busy forced on readiness loss", busy[0], 1);
        chk("R10 pending cleared on readiness loss", pending[0], 0);
        init_done = 1'b1;
        tick(); tick();
        chk("R10 idle after readiness returns", busy[0], 0);
        sc_rdata = 8'hEE;
        complete[0] = 1'b1; tick(); complete[0] = 1'b0;
        chk("R10 flushed request cannot complete", rvalid[0], 0);
        chk("R10 read data not loaded after flush", rdata[0] == 8'hEE, 0);
    endtask

    task automatic t_independent();
        wr[0] = 1'b1; addr[0] = 24'h0C0C0C; wdata[0] = 8'h33; strobe[0] = 1'b1;
        tick();
        strobe[0] = 1'b0;
        run_req(1, 1'b0, 32'h0D0D0D, 32'h00, 32'h81);
        chk("R11 other channel still pending", pending[0], 1);
        chk("R11 other channel fields intact", rq_addr[0], 24'h0C0C0C);
        chk("R11 other channel no read valid", rvalid[0], 0);
        accept[0] = 1'b1; tick(); accept[0] = 1'b0;
        complete[0] = 1'b1; tick(); complete[0] = 1'b0;
        chk("R11 other channel completes", busy[0], 0);
        chk("R11 finished channel untouched", rdata[1], 8'h81);
    endtask

    initial begin
        t_reset();
        t_not_ready();
        t_read_write();
        t_held_strobe();
        t_busy_strobe();
        t_stray_events();
        t_flush();
        t_independent();
        done_flag = 1;
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule